// File: doc/BRIEF.md
# Packet Buffer Front End with Loopback-Ready Byte Streams

This block sits between a register bus and a packet MAC. Software builds an outgoing frame by writing its bytes into a transmit window, using whole words, halfwords or single bytes. It then programs the frame length and writes a trigger. The block queues the frame in one of two transmit slots and plays it out as a byte stream. Incoming frames arrive on a second byte stream. They are captured into a two-slot receive ring and shown to software one at a time, through a read window and a length register.

A receive pending flag reports that a captured frame is waiting. A transmit pending flag reports that the transmit queue has just left its full state. Each flag has its own enable, and the two gated flags are merged into one interrupt line.

Both stream ports use valid/ready. A beat transfers on a rising clock edge where valid and ready are both high. The transmit side holds valid, data and last unchanged while ready is low. The receive side never applies back-pressure. It keeps ready high and discards frames it cannot store. Because of this, the transmit stream can be wired straight to the receive stream as a loopback, with an optional stall gate between them.

Top module: `pkt_buf_ctrl`

## Requirements
- R1: After reset, irq and tx_valid are 0, and reads of the receive length, both pending flags, both enables and the transmit length return 0.
- R2: A write to byte address 0x0800+4k updates, for each lane j with bus_be[j]=1, frame offset 4k+j with bus_wdata[8j+7:8j]. Lanes whose enable bit is 0 are left unchanged.
- R3: A write of bit 0 = 1 to 0x1018 queues the frame being filled, with the length held at 0x1028 (values above the slot size are clamped to it). The frame is emitted in offset order, one byte per beat, with tx_last set on its final byte only. A trigger while the length is 0 queues nothing.
- R4: While tx_valid is 1 and tx_ready is 0, tx_valid, tx_data and tx_last keep their values into the next cycle. rx_ready is always 1.
- R5: Incoming bytes are stored from offset 0 up to the beat marked rx_last, which completes the frame. Bit 0 of 0x1010 then reads 1 and 0x1004 reads the byte count. A read of 0x0000+4k returns offsets 4k..4k+3 in lanes 0..3.
- R6: A write of bit 0 = 1 to 0x1010 releases the shown frame. If another frame is stored, it is shown at once and pending stays 1. A write of bit 0 = 0 has no effect.
- R7: A frame whose first byte arrives while both receive slots hold frames is dropped whole. The stored frames are unchanged.
- R8: With two frames queued and not fully sent, the transmit side is full. In that state a trigger is ignored, and writes to the transmit window are ignored.
- R9: The transmit pending flag (bit 0 of 0x1030) is set on the clock edge where the queue leaves the full state. A write of bit 0 = 1 clears it, and a write of bit 0 = 0 has no effect.
- R10: irq = (receive pending AND receive enable) OR (transmit pending AND transmit enable). Enable registers 0x1014 (receive) and 0x1034 (transmit) take bit 0 of the last write. Flag and enable registers read their state in bit 0 and zero in all other bits.
- R11: bus_rdata holds the read result from the cycle after the read request. Reads of the transmit window and of the trigger register return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 13 | Byte address relative to the block base |
| bus_be | input | 4 | Byte lane enables for window writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| irq | output | 1 | Merged interrupt request |
| tx_valid | output | 1 | Transmit byte valid |
| tx_ready | input | 1 | Transmit byte accepted |
| tx_data | output | 8 | Transmit byte |
| tx_last | output | 1 | Final byte of the transmit frame |
| rx_valid | input | 1 | Receive byte valid |
| rx_ready | output | 1 | Receive ready, always 1 |
| rx_data | input | 8 | Receive byte |
| rx_last | input | 1 | Final byte of the receive frame |

## Verification
Register writes take effect on the edge that samples them. A read result appears on bus_rdata just after the next edge. The bench drives each access one cycle wide and samples a result 1 ns after the edge that produced it. Flag and interrupt effects show up on the edge that completes a frame, or on the edge that accepts the write. Both irq and the pending flags are therefore checked right after the bus write returns, or after the stream has drained and a few idle edges have passed. Transmit bytes are compared beat by beat at the falling edge, against a queue filled by the driver when it issues a trigger. A queue that does not drain within its time limit counts as a failure.

// File: rtl/pkt_buf_pkg.sv
package pkt_buf_pkg;
  localparam int BUS_AW = 13;

  localparam logic [BUS_AW-1:0] OFS_RX_LEN  = 13'h1004;
  localparam logic [BUS_AW-1:0] OFS_RX_PEND = 13'h1010;
  localparam logic [BUS_AW-1:0] OFS_RX_EN   = 13'h1014;
  localparam logic [BUS_AW-1:0] OFS_SEND    = 13'h1018;
  localparam logic [BUS_AW-1:0] OFS_TX_LEN  = 13'h1028;
  localparam logic [BUS_AW-1:0] OFS_TX_PEND = 13'h1030;
  localparam logic [BUS_AW-1:0] OFS_TX_EN   = 13'h1034;

  // windows decoded on address bits [12:11]
  localparam logic [1:0] WIN_RX_SEL = 2'b00;
  localparam logic [1:0] WIN_TX_SEL = 2'b01;

  typedef struct packed {
    logic       last;
    logic [7:0] data;
  } beat_t;
endpackage

// File: rtl/pkt_tx_path.sv
module pkt_tx_path #(
  parameter int SLOT_BYTES = 2048,
  parameter int SLOTS      = 2,
  localparam int WORDS  = SLOT_BYTES / 4,
  localparam int WA_W   = $clog2(WORDS),
  localparam int IDX_W  = $clog2(SLOT_BYTES),
  localparam int LEN_W  = $clog2(SLOT_BYTES + 1),
  localparam int SLOT_W = $clog2(SLOTS),
  localparam int CNT_W  = $clog2(SLOTS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WA_W-1:0]  wr_word,
  input  logic [3:0]       wr_be,
  input  logic [31:0]      wr_data,
  input  logic             send_req,
  input  logic [LEN_W-1:0] send_len,
  output logic             out_valid,
  input  logic             out_ready,
  output pkt_buf_pkg::beat_t out_beat,
  output logic             full,
  output logic             full_fall
);
  localparam int DEPTH = SLOTS * WORDS;

  logic [SLOT_W-1:0] wslot_q, rslot_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [IDX_W-1:0]  idx_q;
  logic [LEN_W-1:0]  slot_len_q [SLOTS];
  logic [7:0]        lane_rd [4];
  logic              push, pop, fire;

  assign full      = (cnt_q == CNT_W'(SLOTS));
  assign push      = send_req && !full && (send_len != '0);
  assign out_valid = (cnt_q != '0);
  assign fire      = out_valid && out_ready;
  assign pop       = fire && out_beat.last;
  assign full_fall = full && pop;

  // one storage array per byte lane
  for (genvar ln = 0; ln < 4; ln++) begin : g_lane
    logic [7:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (wr_en && !full && wr_be[ln])
        mem[{wslot_q, wr_word}] <= wr_data[8*ln +: 8];
    end
    assign lane_rd[ln] = mem[{rslot_q, idx_q[IDX_W-1:2]}];
  end

  assign out_beat.data = lane_rd[idx_q[1:0]];
  assign out_beat.last = ((LEN_W'(idx_q) + LEN_W'(1)) == slot_len_q[rslot_q]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wslot_q <= '0;
      rslot_q <= '0;
      cnt_q   <= '0;
      idx_q   <= '0;
      for (int s = 0; s < SLOTS; s++) slot_len_q[s] <= '0;
    end else begin
      if (push) begin
        slot_len_q[wslot_q] <= send_len;
        wslot_q <= wslot_q + SLOT_W'(1);
      end
      if (fire) begin
        if (out_beat.last) begin
          idx_q   <= '0;
          rslot_q <= rslot_q + SLOT_W'(1);
        end else begin
          idx_q <= idx_q + IDX_W'(1);
        end
      end
      cnt_q <= cnt_q + CNT_W'(push) - CNT_W'(pop);
    end
  end
endmodule

// File: rtl/pkt_rx_path.sv
module pkt_rx_path #(
  parameter int SLOT_BYTES = 2048,
  parameter int SLOTS      = 2,
  localparam int WORDS  = SLOT_BYTES / 4,
  localparam int WA_W   = $clog2(WORDS),
  localparam int IDX_W  = $clog2(SLOT_BYTES),
  localparam int LEN_W  = $clog2(SLOT_BYTES + 1),
  localparam int SLOT_W = $clog2(SLOTS),
  localparam int CNT_W  = $clog2(SLOTS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  pkt_buf_pkg::beat_t in_beat,
  output logic             in_ready,
  input  logic [WA_W-1:0]  rd_word,
  output logic [31:0]      rd_data,
  output logic [LEN_W-1:0] cur_len,
  output logic             avail,
  output logic [CNT_W-1:0] held,
  input  logic             release_req
);
  localparam int DEPTH = SLOTS * WORDS;

  logic [SLOT_W-1:0] wslot_q, rslot_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [LEN_W-1:0]  widx_q;
  logic [LEN_W-1:0]  slot_len_q [SLOTS];
  logic              in_frame_q, dropping_q;
  logic              beat, drop_now, room, store, pop;
  logic [SLOT_W+WA_W-1:0] waddr;

  assign in_ready = 1'b1;
  assign beat     = in_valid && in_ready;
  assign drop_now = in_frame_q ? dropping_q : (cnt_q == CNT_W'(SLOTS));
  assign room     = (widx_q < LEN_W'(SLOT_BYTES));
  assign store    = beat && in_beat.last && !drop_now;
  assign pop      = release_req && (cnt_q != '0);
  assign avail    = (cnt_q != '0);
  assign held     = cnt_q;
  assign cur_len  = avail ? slot_len_q[rslot_q] : '0;
  assign waddr    = {wslot_q, widx_q[IDX_W-1:2]};

  for (genvar ln = 0; ln < 4; ln++) begin : g_lane
    logic [7:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (beat && !drop_now && room && (widx_q[1:0] == 2'(ln)))
        mem[waddr] <= in_beat.data;
    end
    assign rd_data[8*ln +: 8] = mem[{rslot_q, rd_word}];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wslot_q    <= '0;
      rslot_q    <= '0;
      cnt_q      <= '0;
      widx_q     <= '0;
      in_frame_q <= 1'b0;
      dropping_q <= 1'b0;
      for (int s = 0; s < SLOTS; s++) slot_len_q[s] <= '0;
    end else begin
      if (beat) begin
        if (in_beat.last) begin
          in_frame_q <= 1'b0;
          dropping_q <= 1'b0;
          widx_q     <= '0;
          if (!drop_now) begin
            slot_len_q[wslot_q] <= room ? widx_q + LEN_W'(1) : widx_q;
            wslot_q <= wslot_q + SLOT_W'(1);
          end
        end else begin
          in_frame_q <= 1'b1;
          dropping_q <= drop_now;
          if (room) widx_q <= widx_q + LEN_W'(1);
        end
      end
      if (pop) rslot_q <= rslot_q + SLOT_W'(1);
      cnt_q <= cnt_q + CNT_W'(store) - CNT_W'(pop);
    end
  end
endmodule

// File: rtl/pkt_irq_ctrl.sv
module pkt_irq_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_avail,
  input  logic tx_evt,
  input  logic tx_clr,
  input  logic rx_en_we,
  input  logic tx_en_we,
  input  logic en_bit,
  output logic tx_pend,
  output logic rx_en,
  output logic tx_en,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_pend <= 1'b0;
      rx_en   <= 1'b0;
      tx_en   <= 1'b0;
    end else begin
      if (tx_evt)      tx_pend <= 1'b1;
      else if (tx_clr) tx_pend <= 1'b0;
      if (rx_en_we) rx_en <= en_bit;
      if (tx_en_we) tx_en <= en_bit;
    end
  end

  assign irq = (rx_avail && rx_en) || (tx_pend && tx_en);
endmodule

// File: rtl/pkt_buf_ctrl.sv
module pkt_buf_ctrl
  import pkt_buf_pkg::*;
#(
  parameter int SLOT_BYTES = 2048,
  parameter int SLOTS      = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_we,
  input  logic [12:0] bus_addr,
  input  logic [3:0]  bus_be,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq,
  output logic        tx_valid,
  input  logic        tx_ready,
  output logic [7:0]  tx_data,
  output logic        tx_last,
  input  logic        rx_valid,
  output logic        rx_ready,
  input  logic [7:0]  rx_data,
  input  logic        rx_last
);
  localparam int WA_W  = $clog2(SLOT_BYTES / 4);
  localparam int LEN_W = $clog2(SLOT_BYTES + 1);
  localparam int CNT_W = $clog2(SLOTS + 1);

  logic wr, rd, tx_win, rx_win;
  logic send_req, rx_clr, tx_clr, rx_en_we, tx_en_we, txlen_we;
  logic tx_full, tx_fall, rx_avail, tx_pend, rx_en, tx_en;
  logic [LEN_W-1:0] tx_len_q, rx_len;
  logic [CNT_W-1:0] rx_cnt;
  logic [31:0] rx_word;
  beat_t tx_beat, rx_beat;

  assign wr       = bus_sel && bus_we;
  assign rd       = bus_sel && !bus_we;
  assign tx_win   = (bus_addr[12:11] == WIN_TX_SEL);
  assign rx_win   = (bus_addr[12:11] == WIN_RX_SEL);
  assign send_req = wr && (bus_addr == OFS_SEND) && bus_wdata[0];
  assign rx_clr   = wr && (bus_addr == OFS_RX_PEND) && bus_wdata[0];
  assign tx_clr   = wr && (bus_addr == OFS_TX_PEND) && bus_wdata[0];
  assign rx_en_we = wr && (bus_addr == OFS_RX_EN);
  assign tx_en_we = wr && (bus_addr == OFS_TX_EN);
  assign txlen_we = wr && (bus_addr == OFS_TX_LEN);

  always_ff @(posedge clk) begin
    if (!rst_n) tx_len_q <= '0;
    else if (txlen_we)
      tx_len_q <= (bus_wdata > 32'(SLOT_BYTES)) ? LEN_W'(SLOT_BYTES)
                                                : bus_wdata[LEN_W-1:0];
  end

  pkt_tx_path #(.SLOT_BYTES(SLOT_BYTES), .SLOTS(SLOTS)) u_tx (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr && tx_win), .wr_word(bus_addr[WA_W+1:2]), .wr_be(bus_be),
    .wr_data(bus_wdata), .send_req(send_req), .send_len(tx_len_q),
    .out_valid(tx_valid), .out_ready(tx_ready), .out_beat(tx_beat),
    .full(tx_full), .full_fall(tx_fall)
  );
  assign tx_data = tx_beat.data;
  assign tx_last = tx_beat.last;

  assign rx_beat.data = rx_data;
  assign rx_beat.last = rx_last;

  pkt_rx_path #(.SLOT_BYTES(SLOT_BYTES), .SLOTS(SLOTS)) u_rx (
    .clk(clk), .rst_n(rst_n),
    .in_valid(rx_valid), .in_beat(rx_beat), .in_ready(rx_ready),
    .rd_word(bus_addr[WA_W+1:2]), .rd_data(rx_word), .cur_len(rx_len),
    .avail(rx_avail), .held(rx_cnt), .release_req(rx_clr)
  );

  pkt_irq_ctrl u_irq (
    .clk(clk), .rst_n(rst_n), .rx_avail(rx_avail), .tx_evt(tx_fall),
    .tx_clr(tx_clr), .rx_en_we(rx_en_we), .tx_en_we(tx_en_we),
    .en_bit(bus_wdata[0]), .tx_pend(tx_pend), .rx_en(rx_en),
    .tx_en(tx_en), .irq(irq)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) bus_rdata <= '0;
    else if (rd) begin
      if (rx_win) bus_rdata <= rx_word;
      else begin
        case (bus_addr)
          OFS_RX_LEN:  bus_rdata <= 32'(rx_len);
          OFS_RX_PEND: bus_rdata <= {31'b0, rx_avail};
          OFS_RX_EN:   bus_rdata <= {31'b0, rx_en};
          OFS_TX_LEN:  bus_rdata <= 32'(tx_len_q);
          OFS_TX_PEND: bus_rdata <= {31'b0, tx_pend};
          OFS_TX_EN:   bus_rdata <= {31'b0, tx_en};
          default:     bus_rdata <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/pkt_buf_ctrl_chk.sv
module pkt_buf_ctrl_chk #(
  parameter int SLOTS = 2,
  parameter int CNT_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tx_valid,
  input logic             tx_ready,
  input logic [7:0]       tx_data,
  input logic             tx_last,
  input logic             irq,
  input logic             rx_avail,
  input logic             rx_en,
  input logic             tx_pend,
  input logic             tx_en,
  input logic             tx_full,
  input logic             send_req,
  input logic [CNT_W-1:0] rx_cnt
);
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last)); // R4

  AST_FULL_IGNORES_SEND: assert property (@(posedge clk) disable iff (!rst_n)
    tx_full && send_req && !(tx_valid && tx_ready && tx_last) |=> tx_full); // R8

  AST_TX_PEND_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_pend) |-> $past(tx_full) && !tx_full); // R9

  AST_IRQ_MERGE: assert property (@(posedge clk) disable iff (!rst_n)
    irq == ((rx_avail && rx_en) || (tx_pend && tx_en))); // R10

  AST_RX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    rx_cnt <= CNT_W'(SLOTS)); // R7
endmodule

bind pkt_buf_ctrl pkt_buf_ctrl_chk #(.SLOTS(SLOTS), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .tx_data(tx_data), .tx_last(tx_last), .irq(irq), .rx_avail(rx_avail),
  .rx_en(rx_en), .tx_pend(tx_pend), .tx_en(tx_en), .tx_full(tx_full),
  .send_req(send_req), .rx_cnt(rx_cnt)
);

// File: tb/pkt_buf_ctrl_bench.sv
`timescale 1ns/1ps
module pkt_buf_ctrl_bench;
  localparam logic [12:0] A_TXW = 13'h0800, A_RXLEN = 13'h1004,
    A_RXP = 13'h1010, A_RXEN = 13'h1014, A_SEND = 13'h1018,
    A_TXLEN = 13'h1028, A_TXP = 13'h1030, A_TXEN = 13'h1034;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sel = 1'b0, we = 1'b0, hold = 1'b0;
  logic [12:0] addr = '0;
  logic [3:0] be = '0;
  logic [31:0] wdata = '0, rdata;
  logic irq, tx_valid, tx_ready, tx_last, rx_valid, rx_ready, rx_last;
  logic [7:0] tx_data, rx_data;
  int total = 0, bad = 0;
  bit finished = 1'b0;
  logic [8:0] exp_q[$];

  always #2.5 clk = ~clk;

  // loopback with a stall gate
  assign tx_ready = rx_ready && !hold;
  assign rx_valid = tx_valid && !hold;
  assign rx_data  = tx_data;
  assign rx_last  = tx_last;

  pkt_buf_ctrl u_pkt_buf_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_we(we), .bus_addr(addr),
    .bus_be(be), .bus_wdata(wdata), .bus_rdata(rdata), .irq(irq),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .tx_last(tx_last), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_data(rx_data), .rx_last(rx_last)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] fbyte(input int id, input int i);
    return (i == 0) ? 8'(id) : 8'(i % 64);
  endfunction

  task automatic bus_wr(input logic [12:0] a, input logic [31:0] d, input logic [3:0] b);
    @(posedge clk); #1;
    sel = 1'b1; we = 1'b1; addr = a; wdata = d; be = b;
    @(posedge clk); #1;
    sel = 1'b0; we = 1'b0;
  endtask

  task automatic bus_rd(input logic [12:0] a, output logic [31:0] d);
    @(posedge clk); #1;
    sel = 1'b1; we = 1'b0; addr = a;
    @(posedge clk); #1;
    sel = 1'b0;
    d = rdata;
  endtask

  task automatic load_frame(input int id, input int len);
    int w = len / 4;
    int base = 4 * w;
    for (int k = 0; k < w; k++)
      bus_wr(A_TXW + 13'(4*k), {fbyte(id,4*k+3), fbyte(id,4*k+2),
             fbyte(id,4*k+1), fbyte(id,4*k)}, 4'hF);
    case (len % 4)
      1: bus_wr(A_TXW + 13'(base), {24'h0, fbyte(id,base)}, 4'b0001);
      2: bus_wr(A_TXW + 13'(base), {16'h0, fbyte(id,base+1), fbyte(id,base)}, 4'b0011);
      3: begin
        bus_wr(A_TXW + 13'(base), {16'h0, fbyte(id,base+1), fbyte(id,base)}, 4'b0011);
        bus_wr(A_TXW + 13'(base), {8'h0, fbyte(id,base+2), 16'h0}, 4'b0100);
      end
      default: ;
    endcase
    bus_wr(A_TXLEN, 32'(len), 4'hF);
  endtask

  // driver: expected beats go into the scoreboard before the trigger
  task automatic send(input int id, input int len);
    for (int i = 0; i < len; i++) exp_q.push_back({(i == len-1), fbyte(id, i)});
    bus_wr(A_SEND, 32'h1, 4'hF);
  endtask

  task automatic wait_drain(input string req);
    int t = 0;
    while (exp_q.size() != 0 && t < 20000) begin
      @(posedge clk); t++;
    end
    repeat (4) @(posedge clk);
    chk(req, 32'(exp_q.size()), 32'd0);
  endtask

  task automatic check_rx(input string req, input int id, input int len);
    logic [31:0] d;
    int errs = 0;
    bus_rd(A_RXLEN, d);
    chk({req, " length"}, d, 32'(len));
    for (int k = 0; k < (len + 3) / 4; k++) begin
      bus_rd(13'(4*k), d);
      for (int j = 0; j < 4; j++)
        if (4*k + j < len && d[8*j +: 8] !== fbyte(id, 4*k+j)) errs++;
    end
    chk({req, " bytes"}, 32'(errs), 32'd0);
  endtask

  // monitor: compare each accepted transmit beat with the scoreboard
  always @(negedge clk) begin
    if (rst_n && tx_valid && tx_ready) begin
      if (exp_q.size() == 0) begin
        total++; bad++;
        $display("FAIL R3 actual=%h expected=none (unexpected beat)", {tx_last, tx_data});
      end else begin
        logic [8:0] e;
        e = exp_q.pop_front();
        chk("R3 stream beat", 32'({tx_last, tx_data}), 32'(e));
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    chk("R1 irq", 32'(irq), 0);
    chk("R1 tx_valid", 32'(tx_valid), 0);
    bus_rd(A_RXP, d);   chk("R1 rx pending", d, 0);
    bus_rd(A_RXLEN, d); chk("R1 rx length", d, 0);
    bus_rd(A_TXP, d);   chk("R1 tx pending", d, 0);
    bus_rd(A_TXLEN, d); chk("R1 tx length", d, 0);
    bus_rd(A_RXEN, d);  chk("R1 rx enable", d, 0);
    bus_rd(A_TXEN, d);  chk("R1 tx enable", d, 0);

    // R3 zero length trigger queues nothing
    bus_wr(A_SEND, 32'h1, 4'hF);
    repeat (3) @(posedge clk);
    #1 chk("R3 zero length", 32'(tx_valid), 0);

    // R2 R3 R5 lane writes, stream and capture (tail of 3 bytes)
    load_frame(1, 7);
    send(1, 7);
    wait_drain("R3 drain");
    bus_rd(A_RXP, d); chk("R5 rx pending", d, 32'h1);
    check_rx("R5 R2 frame1", 1, 7);
    chk("R10 irq gated off", 32'(irq), 0);
    bus_wr(A_RXEN, 32'h1, 4'hF);
    chk("R10 irq rx", 32'(irq), 1);
    bus_wr(A_RXP, 32'h0, 4'hF);
    bus_rd(A_RXP, d); chk("R6 write zero no effect", d, 32'h1);
    bus_wr(A_RXP, 32'h1, 4'hF);
    chk("R6 irq after clear", 32'(irq), 0);
    bus_rd(A_RXP, d); chk("R6 cleared", d, 0);
    bus_wr(A_RXEN, 32'h0, 4'hF);
    bus_rd(A_RXEN, d); chk("R10 enable off", d, 0);

    // R11 write-only locations read zero
    bus_rd(A_TXW, d);  chk("R11 tx window read", d, 0);
    bus_rd(A_SEND, d); chk("R11 trigger read", d, 0);

    // R6 two frames, advance on clear (tails 1 and 2)
    load_frame(2, 5);
    send(2, 5);
    load_frame(3, 6);
    send(3, 6);
    wait_drain("R3 drain two");
    check_rx("R6 first", 2, 5);
    bus_wr(A_RXP, 32'h1, 4'hF);
    bus_rd(A_RXP, d); chk("R6 pending stays", d, 32'h1);
    check_rx("R6 second", 3, 6);
    bus_wr(A_RXP, 32'h1, 4'hF);
    bus_rd(A_RXP, d); chk("R6 empty", d, 0);

    // R5 large frame
    load_frame(4, 1024);
    send(4, 1024);
    wait_drain("R3 drain large");
    check_rx("R5 large", 4, 1024);
    bus_wr(A_RXP, 32'h1, 4'hF);

    // R8 R9 full transmit queue under stall
    @(posedge clk); #1 hold = 1'b1;
    load_frame(10, 6);
    send(10, 6);
    load_frame(11, 9);
    send(11, 9);
    bus_wr(A_TXW, 32'hFFFF_FFFF, 4'hF);   // ignored while full
    bus_wr(A_SEND, 32'h1, 4'hF);          // ignored while full
    bus_rd(A_TXP, d); chk("R9 no pending while full", d, 0);
    chk("R4 held valid", 32'(tx_valid), 1);
    chk("R8 head byte intact", 32'(tx_data), 32'd10);
    @(posedge clk); #1 hold = 1'b0;
    wait_drain("R8 drain only two");
    chk("R8 idle after two", 32'(tx_valid), 0);
    bus_rd(A_TXP, d); chk("R9 pending set", d, 32'h1);
    chk("R10 irq tx gated off", 32'(irq), 0);
    bus_wr(A_TXEN, 32'h1, 4'hF);
    chk("R10 irq tx", 32'(irq), 1);
    bus_wr(A_TXP, 32'h0, 4'hF);
    bus_rd(A_TXP, d); chk("R9 write zero no effect", d, 32'h1);
    bus_wr(A_TXP, 32'h1, 4'hF);
    chk("R9 irq after clear", 32'(irq), 0);
    bus_rd(A_TXP, d); chk("R9 cleared", d, 0);

    // R7 both receive slots hold frames 10 and 11; frame 12 is dropped
    load_frame(12, 4);
    send(12, 4);
    wait_drain("R3 drain dropped");
    check_rx("R7 first kept", 10, 6);
    bus_wr(A_RXP, 32'h1, 4'hF);
    check_rx("R7 second kept", 11, 9);
    bus_wr(A_RXP, 32'h1, 4'hF);
    bus_rd(A_RXP, d); chk("R7 third dropped", d, 0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule